// File: doc/BRIEF.md
# Sine-Wave Cell Delay Calibration Accumulator

This block measures how long each sampling cell of a fast analog sampler stays open. A free-running sine wave, unrelated in phase to the sampler, is captured frame after frame. In every frame the block looks for pairs of neighbouring samples that sit on opposite sides of zero. Near zero the sine is close to a straight line, so the amplitude step of such a pair grows with the time step of the earlier cell. For each cell the block keeps a hit count, a sum of these steps and a sum of their squares.

Software writes the number of frames and pulses `start`. After that many complete frames the block runs one pass over all cells. A single shared serial divider produces, for each cell, the mean step (the fixed-pattern delay, which gives the DNL), the variance (the random aperture jitter) and the running sum of the means of all lower cells (the INL). When `done` is high the results can be read through a cell-indexed port.

Top module: `cell_delay_cal`

## Requirements
- R1: After reset, `busy` and `done` are both 0.
- R2: Within a frame, two consecutive samples whose sign bits (bit SAMPLE_W-1 of the two's-complement value) differ form a crossing. A value of zero counts as non-negative. Rising and falling crossings both count. The crossing adds one hit, a length of |later - earlier|, and that length squared to the cell of the earlier sample.
- R3: No pair is formed across a frame boundary, so the last cell (N_CELLS-1) never collects a hit.
- R4: A `start` pulse clears all accumulators and results, drops `done` and latches `cfg_events`. The run then collects exactly that many frames. A frame is one sample with `smp_first`=1 (cell 0) followed by N_CELLS-1 further valid samples. Valid samples that arrive while no frame is open, or while the block is not collecting, have no effect.
- R5: `busy` is high from the cycle after `start` until the post-processing pass ends. `done` then goes high and stays high until the next `start`. `busy` and `done` are never high together.
- R6: For a cell with hits, `rd_mean` = floor(sum / hits).
- R7: For a cell with hits, `rd_var` = floor(sum_of_squares / hits) - rd_mean².
- R8: `rd_inl` of cell 0 is 0, and `rd_inl` of cell k is `rd_inl` of cell k-1 plus `rd_mean` of cell k-1.
- R9: A cell with zero hits reads `rd_fault`=1 with `rd_mean`=0 and `rd_var`=0. It adds nothing to the INL of higher cells.
- R10: With `cfg_events`=0 the run ends at once and every cell reports a fault.
- R11: A `smp_first` sample that arrives before the current frame is complete restarts at cell 0. The unfinished frame is not counted toward `cfg_events`, but the crossings it already produced are kept. No pair is formed across the restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Clears the accumulators and begins a calibration run |
| cfg_events | input | CNT_W | Number of complete frames to collect, latched on `start` |
| smp_valid | input | 1 | A sample is present this cycle |
| smp_first | input | 1 | The present sample belongs to cell 0 of a new frame |
| smp_data | input | SAMPLE_W | Two's-complement sample value |
| busy | output | 1 | A run or the post-processing pass is in progress |
| done | output | 1 | Results are ready to read |
| rd_cell | input | CELL_W | Cell index to read |
| rd_mean | output | LEN_W | Mean crossing length of the selected cell |
| rd_var | output | SQ_W | Variance of the crossing length of the selected cell |
| rd_inl | output | INL_W | Sum of the means of all lower cells |
| rd_fault | output | 1 | The selected cell collected no crossing |

## Verification
The block is driven with several kinds of frames:
- A frame with a single dip below zero gives one falling and one rising crossing. This shows that both directions are counted and that each is charged to the earlier cell.
- Multi-frame runs with lengths that change from frame to frame give a non-zero variance. They check the floor rules for the mean and the variance against an independent running model, and they check the INL chain, including faulted cells that contribute nothing.
- Frames that contain exact zeros separate "zero is non-negative" from a sign test that treats zero as a crossing.
- Other runs check the remaining rules: a truncated frame followed by a restart, stray samples outside a frame and after completion, a second run after an earlier one (clearing), and a run of zero frames.

// File: rtl/caldl_pkg.sv
// Shared definitions for the cell delay calibration block.
// Assumes: one top-level sequencer uses the state type below.
package caldl_pkg;

    // Top-level sequencer states: collect, then one post-processing pass per cell
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_CELL,
        ST_WMEAN,
        ST_WVAR,
        ST_DONE
    } cal_state_t;

endpackage

// File: rtl/caldl_front.sv
// Frame tracker and zero-crossing detector.
// Follows the cell index inside a frame and compares each accepted sample
// with the previous one. When their sign bits differ it emits, one cycle
// later, a hit for the earlier cell together with the absolute step.
// Assumes: samples of one frame arrive in cell order. smp_first marks cell 0.
module caldl_front #(
    parameter int N_CELLS  = 16,
    parameter int SAMPLE_W = 12,
    parameter int CELL_W   = $clog2(N_CELLS),
    parameter int LEN_W    = SAMPLE_W + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       enable,
    input  logic                       smp_valid,
    input  logic                       smp_first,
    input  logic signed [SAMPLE_W-1:0] smp_data,
    output logic                       frame_end,
    output logic                       hit_q,
    output logic [CELL_W-1:0]          hit_cell_q,
    output logic [LEN_W-1:0]           hit_len_q
);
    localparam logic [CELL_W-1:0] LAST_CELL = CELL_W'(N_CELLS - 1);

    logic                       in_frame;
    logic [CELL_W-1:0]          nxt_cell;
    logic [CELL_W-1:0]          cur_cell;
    logic signed [SAMPLE_W-1:0] prev;
    logic                       accept;
    logic                       crossing;
    logic signed [LEN_W-1:0]    diff;
    logic [LEN_W-1:0]           len;

    // Decode the present sample: does it count, which cell, is it a crossing
    always_comb begin
        accept    = enable && smp_valid && (smp_first || in_frame);
        cur_cell  = smp_first ? '0 : nxt_cell;
        diff      = {smp_data[SAMPLE_W-1], smp_data} - {prev[SAMPLE_W-1], prev};
        len       = diff[LEN_W-1] ? LEN_W'(-diff) : LEN_W'(diff);
        crossing  = accept && (cur_cell != '0) &&
                    (smp_data[SAMPLE_W-1] != prev[SAMPLE_W-1]);
        frame_end = accept && (cur_cell == LAST_CELL);
    end

    // Track frame position and register the crossing result
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            in_frame   <= 1'b0;
            nxt_cell   <= '0;
            prev       <= '0;
            hit_q      <= 1'b0;
            hit_cell_q <= '0;
            hit_len_q  <= '0;
        end else begin
            hit_q      <= crossing;
            hit_cell_q <= cur_cell - CELL_W'(1);
            hit_len_q  <= len;
            if (accept) begin
                prev <= smp_data;
                if (cur_cell == LAST_CELL) begin
                    in_frame <= 1'b0;
                    nxt_cell <= '0;
                end else begin
                    in_frame <= 1'b1;
                    nxt_cell <= cur_cell + CELL_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/caldl_accum.sv
// Per-cell statistics store: hit count, sum of lengths, sum of squared lengths.
// Assumes: at most one hit per cycle, and counts stay below 2**CNT_W
// (at most one hit per cell per frame).
module caldl_accum #(
    parameter int N_CELLS = 16,
    parameter int CELL_W  = $clog2(N_CELLS),
    parameter int LEN_W   = 13,
    parameter int CNT_W   = 16,
    parameter int SUM_W   = 32,
    parameter int SQ_W    = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              hit,
    input  logic [CELL_W-1:0] hit_cell,
    input  logic [LEN_W-1:0]  hit_len,
    input  logic [CELL_W-1:0] rd_idx,
    output logic [CNT_W-1:0]  rd_cnt,
    output logic [SUM_W-1:0]  rd_sum,
    output logic [SQ_W-1:0]   rd_sq
);
    localparam int PROD_W = 2 * LEN_W;

    logic [CNT_W-1:0] cnt_a [N_CELLS];
    logic [SUM_W-1:0] sum_a [N_CELLS];
    logic [SQ_W-1:0]  sq_a  [N_CELLS];
    logic [PROD_W-1:0] len_sq;

    // Square of the incoming length
    always_comb begin
        len_sq = {{LEN_W{1'b0}}, hit_len} * {{LEN_W{1'b0}}, hit_len};
    end

    // Clear on start or add the hit to its cell
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            for (int c = 0; c < N_CELLS; c++) begin
                cnt_a[c] <= '0;
                sum_a[c] <= '0;
                sq_a[c]  <= '0;
            end
        end else if (hit) begin
            cnt_a[hit_cell] <= cnt_a[hit_cell] + CNT_W'(1);
            sum_a[hit_cell] <= sum_a[hit_cell] + SUM_W'(hit_len);
            sq_a[hit_cell]  <= sq_a[hit_cell] + SQ_W'(len_sq);
        end
    end

    // Read port for the post-processing pass
    always_comb begin
        rd_cnt = cnt_a[rd_idx];
        rd_sum = sum_a[rd_idx];
        rd_sq  = sq_a[rd_idx];
    end

endmodule

// File: rtl/caldl_divider.sv
// Restoring unsigned divider that yields one quotient bit per cycle.
// done pulses one cycle after the last step and quo then holds the result.
// Assumes: den is non-zero. go is only pulsed while no division is in flight.
module caldl_divider #(
    parameter int NUM_W = 48,
    parameter int DEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quo
);
    localparam int STEP_W = $clog2(NUM_W + 1);

    logic [DEN_W-1:0]  rem;
    logic [DEN_W-1:0]  den_q;
    logic [STEP_W-1:0] steps;
    logic              running;
    logic [DEN_W:0]    trial;
    logic              fits;

    // Trial subtraction for the next quotient bit
    always_comb begin
        trial = {rem, quo[NUM_W-1]};
        fits  = trial >= {1'b0, den_q};
    end

    // Load the operands, then shift and subtract once per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem     <= '0;
            den_q   <= '0;
            steps   <= '0;
            running <= 1'b0;
            done    <= 1'b0;
            quo     <= '0;
        end else begin
            done <= 1'b0;
            if (go) begin
                rem     <= '0;
                den_q   <= den;
                quo     <= num;
                steps   <= STEP_W'(NUM_W);
                running <= 1'b1;
            end else if (running) begin
                rem   <= fits ? DEN_W'(trial - {1'b0, den_q}) : DEN_W'(trial);
                quo   <= {quo[NUM_W-2:0], fits};
                steps <= steps - STEP_W'(1);
                if (steps == STEP_W'(1)) begin
                    running <= 1'b0;
                    done    <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/caldl_results.sv
// Per-cell result store filled by the post-processing pass and read by index.
// Assumes: one write per cycle at most. A clear returns every entry to zero.
module caldl_results #(
    parameter int N_CELLS = 16,
    parameter int CELL_W  = $clog2(N_CELLS),
    parameter int LEN_W   = 13,
    parameter int SQ_W    = 48,
    parameter int INL_W   = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              we,
    input  logic [CELL_W-1:0] wr_idx,
    input  logic [LEN_W-1:0]  wr_mean,
    input  logic [SQ_W-1:0]   wr_var,
    input  logic [INL_W-1:0]  wr_inl,
    input  logic              wr_fault,
    input  logic [CELL_W-1:0] rd_idx,
    output logic [LEN_W-1:0]  rd_mean,
    output logic [SQ_W-1:0]   rd_var,
    output logic [INL_W-1:0]  rd_inl,
    output logic              rd_fault
);
    logic [LEN_W-1:0] mean_a  [N_CELLS];
    logic [SQ_W-1:0]  var_a   [N_CELLS];
    logic [INL_W-1:0] inl_a   [N_CELLS];
    logic             fault_a [N_CELLS];

    // Store one cell's results, or wipe everything at start
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            for (int c = 0; c < N_CELLS; c++) begin
                mean_a[c]  <= '0;
                var_a[c]   <= '0;
                inl_a[c]   <= '0;
                fault_a[c] <= 1'b0;
            end
        end else if (we) begin
            mean_a[wr_idx]  <= wr_mean;
            var_a[wr_idx]   <= wr_var;
            inl_a[wr_idx]   <= wr_inl;
            fault_a[wr_idx] <= wr_fault;
        end
    end

    // Indexed read-back
    always_comb begin
        rd_mean  = mean_a[rd_idx];
        rd_var   = var_a[rd_idx];
        rd_inl   = inl_a[rd_idx];
        rd_fault = fault_a[rd_idx];
    end

endmodule

// File: rtl/cell_delay_cal.sv
// Sine-wave cell delay calibration accumulator (top level).
// Collects crossing statistics over a programmed number of frames. It then
// visits every cell once, uses a shared serial divider to derive the mean and
// the variance, and chains the means into an INL value.
// Assumes: a frame has exactly N_CELLS samples in cell order. The sample
// source is free-running, so there is no back-pressure.
module cell_delay_cal #(
    parameter int N_CELLS  = 16,
    parameter int SAMPLE_W = 12,
    parameter int CNT_W    = 16,
    parameter int SUM_W    = 32,
    parameter int SQ_W     = 48,
    parameter int CELL_W   = $clog2(N_CELLS),
    parameter int LEN_W    = SAMPLE_W + 1,
    parameter int INL_W    = LEN_W + CELL_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [CNT_W-1:0]           cfg_events,
    input  logic                       smp_valid,
    input  logic                       smp_first,
    input  logic signed [SAMPLE_W-1:0] smp_data,
    output logic                       busy,
    output logic                       done,
    input  logic [CELL_W-1:0]          rd_cell,
    output logic [LEN_W-1:0]           rd_mean,
    output logic [SQ_W-1:0]            rd_var,
    output logic [INL_W-1:0]           rd_inl,
    output logic                       rd_fault
);
    import caldl_pkg::*;

    localparam logic [CELL_W-1:0] LAST_CELL = CELL_W'(N_CELLS - 1);
    localparam int                PROD_W    = 2 * LEN_W;

    cal_state_t        state;
    logic [CNT_W-1:0]  frames;
    logic [CNT_W-1:0]  target;
    logic [CELL_W-1:0] post_cell;
    logic [LEN_W-1:0]  mean_hold;
    logic [INL_W-1:0]  inl_acc;

    logic              collecting;
    logic              frame_end;
    logic              hit_q;
    logic [CELL_W-1:0] hit_cell_q;
    logic [LEN_W-1:0]  hit_len_q;
    logic [CNT_W-1:0]  acc_cnt;
    logic [SUM_W-1:0]  acc_sum;
    logic [SQ_W-1:0]   acc_sq;
    logic              div_go;
    logic [SQ_W-1:0]   div_num;
    logic              div_done;
    logic [SQ_W-1:0]   div_q;
    logic              res_we;
    logic              res_fault;
    logic [LEN_W-1:0]  res_mean;
    logic [SQ_W-1:0]   res_var;
    logic [PROD_W-1:0] mean_sq;
    logic              cell_empty;

    caldl_front #(
        .N_CELLS (N_CELLS),
        .SAMPLE_W(SAMPLE_W),
        .CELL_W  (CELL_W),
        .LEN_W   (LEN_W)
    ) u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start),
        .enable    (collecting),
        .smp_valid (smp_valid),
        .smp_first (smp_first),
        .smp_data  (smp_data),
        .frame_end (frame_end),
        .hit_q     (hit_q),
        .hit_cell_q(hit_cell_q),
        .hit_len_q (hit_len_q)
    );

    caldl_accum #(
        .N_CELLS(N_CELLS),
        .CELL_W (CELL_W),
        .LEN_W  (LEN_W),
        .CNT_W  (CNT_W),
        .SUM_W  (SUM_W),
        .SQ_W   (SQ_W)
    ) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start),
        .hit     (hit_q),
        .hit_cell(hit_cell_q),
        .hit_len (hit_len_q),
        .rd_idx  (post_cell),
        .rd_cnt  (acc_cnt),
        .rd_sum  (acc_sum),
        .rd_sq   (acc_sq)
    );

    caldl_divider #(
        .NUM_W(SQ_W),
        .DEN_W(CNT_W)
    ) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (div_go),
        .num  (div_num),
        .den  (acc_cnt),
        .done (div_done),
        .quo  (div_q)
    );

    caldl_results #(
        .N_CELLS(N_CELLS),
        .CELL_W (CELL_W),
        .LEN_W  (LEN_W),
        .SQ_W   (SQ_W),
        .INL_W  (INL_W)
    ) u_results (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start),
        .we      (res_we),
        .wr_idx  (post_cell),
        .wr_mean (res_mean),
        .wr_var  (res_var),
        .wr_inl  (inl_acc),
        .wr_fault(res_fault),
        .rd_idx  (rd_cell),
        .rd_mean (rd_mean),
        .rd_var  (rd_var),
        .rd_inl  (rd_inl),
        .rd_fault(rd_fault)
    );

    // Control decodes for the collection phase and the post-processing pass
    always_comb begin
        collecting = (state == ST_RUN) && (frames != target);
        cell_empty = (acc_cnt == '0);
        div_go     = ((state == ST_CELL) && !cell_empty) ||
                     ((state == ST_WMEAN) && div_done);
        div_num    = (state == ST_CELL) ? SQ_W'(acc_sum) : acc_sq;
        mean_sq    = {{LEN_W{1'b0}}, mean_hold} * {{LEN_W{1'b0}}, mean_hold};
        res_fault  = (state == ST_CELL);
        res_we     = ((state == ST_CELL) && cell_empty) ||
                     ((state == ST_WVAR) && div_done);
        res_mean   = res_fault ? '0 : mean_hold;
        res_var    = res_fault ? '0 : (div_q - SQ_W'(mean_sq));
        busy       = (state != ST_IDLE) && (state != ST_DONE);
        done       = (state == ST_DONE);
    end

    // Sequencer: collect frames, then visit every cell once
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            frames    <= '0;
            target    <= '0;
            post_cell <= '0;
            mean_hold <= '0;
            inl_acc   <= '0;
        end else if (start) begin
            state     <= ST_RUN;
            frames    <= '0;
            target    <= cfg_events;
            post_cell <= '0;
            mean_hold <= '0;
            inl_acc   <= '0;
        end else begin
            case (state)
                ST_RUN: begin
                    if (frame_end) begin
                        frames <= frames + CNT_W'(1);
                    end
                    if (frames == target) begin
                        state <= ST_CELL;
                    end
                end
                ST_CELL: begin
                    if (!cell_empty) begin
                        state <= ST_WMEAN;
                    end else if (post_cell == LAST_CELL) begin
                        state <= ST_DONE;
                    end else begin
                        post_cell <= post_cell + CELL_W'(1);
                    end
                end
                ST_WMEAN: begin
                    if (div_done) begin
                        mean_hold <= div_q[LEN_W-1:0];
                        state     <= ST_WVAR;
                    end
                end
                ST_WVAR: begin
                    if (div_done) begin
                        inl_acc <= inl_acc + INL_W'(mean_hold);
                        if (post_cell == LAST_CELL) begin
                            state <= ST_DONE;
                        end else begin
                            post_cell <= post_cell + CELL_W'(1);
                            state     <= ST_CELL;
                        end
                    end
                end
                default: state <= state;
            endcase
        end
    end

endmodule

// File: rtl/caldl_check.sv
// Protocol and result-port properties for cell_delay_cal, attached by bind.
module caldl_check #(
    parameter int CELL_W = 4,
    parameter int LEN_W  = 13,
    parameter int SQ_W   = 48,
    parameter int INL_W  = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [CELL_W-1:0] rd_cell,
    input logic [LEN_W-1:0]  rd_mean,
    input logic [SQ_W-1:0]   rd_var,
    input logic [INL_W-1:0]  rd_inl,
    input logic              rd_fault
);
    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!busy && !done));

    assert_busy_done_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_start_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && !done));

    assert_done_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    assert_fault_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rd_fault) |-> (rd_mean == '0 && rd_var == '0));

    assert_inl_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rd_cell == '0) |-> (rd_inl == '0));

endmodule

bind cell_delay_cal caldl_check #(
    .CELL_W(CELL_W),
    .LEN_W (LEN_W),
    .SQ_W  (SQ_W),
    .INL_W (INL_W)
) u_caldl_check (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .rd_cell (rd_cell),
    .rd_mean (rd_mean),
    .rd_var  (rd_var),
    .rd_inl  (rd_inl),
    .rd_fault(rd_fault)
);

// File: tb/test_cell_delay_cal.sv
// Directed bench for cell_delay_cal with an independent statistics model.
module test_cell_delay_cal;
    localparam int CLK_PERIOD = 10;
    localparam int NC  = 16;
    localparam int SW  = 12;
    localparam int CW  = 4;
    localparam int LW  = 13;
    localparam int QW  = 48;
    localparam int IW  = 17;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic [15:0]          cfg_events = '0;
    logic                 smp_valid = 1'b0;
    logic                 smp_first = 1'b0;
    logic signed [SW-1:0] smp_data = '0;
    logic                 busy, done;
    logic [CW-1:0]        rd_cell = '0;
    logic [LW-1:0]        rd_mean;
    logic [QW-1:0]        rd_var;
    logic [IW-1:0]        rd_inl;
    logic                 rd_fault;

    int total = 0;
    int bad = 0;
    int fr [NC];
    longint m_cnt [NC];
    longint m_sum [NC];
    longint m_sq  [NC];

    cell_delay_cal i_cell_delay_cal (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_events(cfg_events),
        .smp_valid(smp_valid), .smp_first(smp_first), .smp_data(smp_data),
        .busy(busy), .done(done), .rd_cell(rd_cell), .rd_mean(rd_mean),
        .rd_var(rd_var), .rd_inl(rd_inl), .rd_fault(rd_fault)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input string what, input longint got, input longint exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic model_clear();
        for (int c = 0; c < NC; c++) begin
            m_cnt[c] = 0; m_sum[c] = 0; m_sq[c] = 0;
        end
    endtask

    task automatic do_start(input int ev);
        @(negedge clk);
        start = 1'b1; cfg_events = 16'(ev);
        @(negedge clk);
        start = 1'b0;
        model_clear();
    endtask

    // Drive fr[0..n-1] as a frame (or a truncated frame). If counted, add its pairs to the model (R2)
    task automatic send_frame(input int n, input bit counted);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            smp_valid = 1'b1; smp_first = (k == 0); smp_data = SW'(fr[k]);
            if (counted && k > 0 && ((fr[k] < 0) != (fr[k-1] < 0))) begin
                longint d = fr[k] - fr[k-1];
                if (d < 0) d = -d;
                m_cnt[k-1] += 1; m_sum[k-1] += d; m_sq[k-1] += d * d;
            end
        end
        @(negedge clk);
        smp_valid = 1'b0; smp_first = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(req, "done reached", longint'(done), 1);
    endtask

    // Compare every cell against the model: mean R6, variance R7, INL R8, fault R9, last cell R3
    task automatic check_all(input string tag);
        longint inl = 0;
        for (int c = 0; c < NC; c++) begin
            longint em, ev;
            @(negedge clk);
            rd_cell = CW'(c);
            #1;
            if (m_cnt[c] == 0) begin
                check("R9", $sformatf("%s cell %0d fault", tag, c), longint'(rd_fault), 1);
                check("R9", $sformatf("%s cell %0d mean", tag, c), longint'(rd_mean), 0);
                em = 0;
            end else begin
                em = m_sum[c] / m_cnt[c];
                ev = m_sq[c] / m_cnt[c] - em * em;
                check("R9", $sformatf("%s cell %0d fault", tag, c), longint'(rd_fault), 0);
                check("R6", $sformatf("%s cell %0d mean", tag, c), longint'(rd_mean), em);
                check("R7", $sformatf("%s cell %0d var", tag, c), longint'(rd_var), ev);
            end
            check("R8", $sformatf("%s cell %0d inl", tag, c), longint'(rd_inl), inl);
            inl += em;
        end
        rd_cell = CW'(NC - 1);
        #1;
        check("R3", $sformatf("%s last cell fault", tag), longint'(rd_fault), 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", "busy after reset", longint'(busy), 0);
        check("R1", "done after reset", longint'(done), 0);
    endtask

    // One dip below zero: a falling then a rising crossing
    task automatic t_single();
        do_start(1);
        check("R5", "busy after start", longint'(busy), 1);
        for (int k = 0; k < NC; k++) fr[k] = 100;
        fr[3] = -10;
        send_frame(NC, 1);
        wait_done("R5");
        check_all("single");
    endtask

    // Several frames with varying lengths, for the mean/variance floors and INL
    task automatic t_multi();
        do_start(5);
        for (int f = 0; f < 5; f++) begin
            for (int k = 0; k < NC; k++) fr[k] = ((k * 37 + f * 53 + k * k * f) % 301) - 150;
            send_frame(NC, 1);
            if (f < 4) check("R4", "not done before last frame", longint'(done), 0);
        end
        wait_done("R4");
        check_all("multi");
    endtask

    // Exact zeros are non-negative (R2)
    task automatic t_zero();
        do_start(2);
        for (int k = 0; k < NC; k++) fr[k] = (k % 4 == 0) ? 0 : ((k % 4 == 1) ? 7 : ((k % 4 == 2) ? -5 : 0));
        send_frame(NC, 1);
        for (int k = 0; k < NC; k++) fr[k] = (k % 2 == 0) ? 0 : -9;
        send_frame(NC, 1);
        wait_done("R2");
        check_all("zero");
    endtask

    // Stray samples before a frame, a truncated frame and a restart (R4, R11)
    task automatic t_restart();
        do_start(1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            smp_valid = 1'b1; smp_first = 1'b0; smp_data = SW'((k % 2 == 0) ? 300 : -300);
        end
        for (int k = 0; k < NC; k++) fr[k] = (k % 2 == 0) ? 40 : -60;
        send_frame(6, 1);
        check("R11", "truncated frame not counted", longint'(busy), 1);
        for (int k = 0; k < NC; k++) fr[k] = (k % 3 == 0) ? -20 : 25;
        send_frame(NC, 1);
        wait_done("R11");
        check_all("restart");
    endtask

    // Samples after completion leave the results alone (R4)
    task automatic t_ignore();
        for (int k = 0; k < NC; k++) fr[k] = (k % 2 == 0) ? 900 : -900;
        send_frame(NC, 0);
        check("R5", "done held", longint'(done), 1);
        check_all("ignore");
    endtask

    task automatic t_zero_events();
        do_start(0);
        wait_done("R10");
        check_all("R10 zero events");
    endtask

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_multi();
        t_zero();
        t_restart();
        t_ignore();
        t_zero_events();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule